// File: doc/BRIEF.md
# Flash Access Control Register

This block is the access control register of an embedded flash controller. It holds five fields: the read wait-state count, the prefetch enable, the low-power read mode, the power-down request and the sleep power-down select. Software reaches the fields through a simple register bus. Each bus access carries an address, write data, a write strobe, and secure and privileged attributes. Read data is combinational from the address and the attributes.

Access is decided field by field. The latency field follows a clock-security input. The three low-power fields follow a separate low-power-security input. A non-secure access to a secured field reads as zero and its write is dropped, and no error is raised. Two privilege controls can also restrict a field to privileged accesses: one applies while the field is secure and the other while it is non-secure. The prefetch enable follows only the non-secure privilege control.

The power-down request can be written only after a two-word key sequence has unlocked it. When the memory reports power-down entry, hardware clears the request and locks the key again. The low-power read bit cannot change while a program or erase is busy or while the write buffer holds data. The sleep power-down select reaches the memory only while no program or erase is running.

Top module: `flash_acr_regs`

## Requirements
- R1: After reset every field is zero. In the control word at byte offset 0x00, latency sits in bits [3:0], prefetch in bit 8, low-power read in bit 11, power-down request in bit 12 and sleep power-down in bit 14. All other bits read zero, and the key location at offset 0x04 always reads zero.
- R2: While `clkSecure` is 1, a non-secure access reads the latency bits as zero and its write leaves latency unchanged. A secure access reads and writes latency normally.
- R3: While `lpSecure` is 1, the low-power read, power-down request and sleep power-down bits behave the same way toward non-secure accesses. The other fields are unaffected.
- R4: A field that is secure is privilege-protected by `secPrivOnly`, and a field that is non-secure by `nsPrivOnly`. An unprivileged access to a protected field reads zero and its write is dropped.
- R5: Prefetch enable is privilege-protected only by `nsPrivOnly`, whatever the security settings.
- R6: A write to the control word leaves the low-power read bit unchanged while `flashBusy` or `wbufPending` is 1.
- R7: The power-down request bit accepts writes only after two consecutive key writes of 0x5A3C96E1 and then 0xA5C3691E. Any other value on either key write locks the key until reset or power-down entry.
- R8: A one-cycle `pdEntered` pulse clears the power-down request bit and returns the key to its locked start state.
- R9: `memSleepPd` equals the sleep power-down bit while `flashBusy` is 0 and is 0 while `flashBusy` is 1.
- R10: The field outputs `latency`, `prefetchEn`, `lowPowerRead` and `pdRequest` always show the stored field values, whatever the access gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busSecure | input | 1 | Access is secure |
| busPriv | input | 1 | Access is privileged |
| busRdata | output | 32 | Read data for the current address and attributes |
| clkSecure | input | 1 | Latency field is secure |
| lpSecure | input | 1 | Low-power fields are secure |
| secPrivOnly | input | 1 | Secure fields require privilege |
| nsPrivOnly | input | 1 | Non-secure fields require privilege |
| flashBusy | input | 1 | Program or erase in progress |
| wbufPending | input | 1 | Write buffer holds data |
| pdEntered | input | 1 | Memory has entered power-down |
| latency | output | 4 | Read wait states |
| prefetchEn | output | 1 | Prefetch enable |
| lowPowerRead | output | 1 | Low-power read mode |
| pdRequest | output | 1 | Power-down request |
| memSleepPd | output | 1 | Power down the memory during sleep |

## Verification
The assertions check five things on every cycle:
- non-secure reads of a secured latency field return zero;
- a gated latency write leaves latency unchanged;
- the low-power read bit holds during any write while busy or while the write buffer is not empty;
- the request bit only rises with the key open and always clears after power-down entry;
- a failed key sequence stays locked.

Only the bench scenarios show the rest:
- the exact bit layout;
- how the two privilege controls combine with the two security inputs;
- that prefetch ignores the secure privilege control;
- the full key unlock, failure and recovery sequence;
- the gating of the sleep select by the busy input.

// File: rtl/flash_acr_pkg.sv
package flash_acr_pkg;

  localparam int LAT_LSB = 0;
  localparam int PRF_BIT = 8;
  localparam int LPM_BIT = 11;
  localparam int PDR_BIT = 12;
  localparam int SLP_BIT = 14;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2,
    KEY_BAD    = 2'd3
  } keyState_t;

  typedef struct packed {
    logic wrLat;
    logic wrPrf;
    logic wrLpm;
    logic wrPdr;
    logic wrSlp;
    logic clrPdr;
    logic showLat;
    logic showPrf;
    logic showLp;
  } acrStrobes_t;

endpackage

// File: rtl/flash_acr_ctrl.sv
module flash_acr_ctrl
  import flash_acr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ACR_OFS = 'h00,
  parameter logic [ADDR_W-1:0] KEY_OFS = 'h04,
  parameter logic [DATA_W-1:0] KEY_A = 32'h5A3C96E1,
  parameter logic [DATA_W-1:0] KEY_B = 32'hA5C3691E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busSecure,
  input  logic              busPriv,
  input  logic              clkSecure,
  input  logic              lpSecure,
  input  logic              secPrivOnly,
  input  logic              nsPrivOnly,
  input  logic              flashBusy,
  input  logic              wbufPending,
  input  logic              pdEntered,
  output acrStrobes_t       stb,
  output logic              keyOpen
);

  keyState_t keyState, keyNext;
  logic selAcr, selKey, latOk, prfOk, lpOk, latPrivReq, lpPrivReq, acrWr;

  assign selAcr = (busAddr == ACR_OFS);
  assign selKey = (busAddr == KEY_OFS);
  assign acrWr  = busWr && selAcr;

  // A secured group is invisible to non-secure accesses; the privilege
  // control that applies depends on the group's current security.
  assign latPrivReq = clkSecure ? secPrivOnly : nsPrivOnly;
  assign lpPrivReq  = lpSecure  ? secPrivOnly : nsPrivOnly;
  assign latOk = !(clkSecure && !busSecure) && !(latPrivReq && !busPriv);
  assign lpOk  = !(lpSecure  && !busSecure) && !(lpPrivReq  && !busPriv);
  assign prfOk = !(nsPrivOnly && !busPriv);

  assign keyOpen = (keyState == KEY_OPEN);

  always_comb begin
    stb         = '0;
    stb.wrLat   = acrWr && latOk;
    stb.wrPrf   = acrWr && prfOk;
    stb.wrLpm   = acrWr && lpOk && !flashBusy && !wbufPending;
    stb.wrPdr   = acrWr && lpOk && keyOpen && !pdEntered;
    stb.wrSlp   = acrWr && lpOk;
    stb.clrPdr  = pdEntered;
    stb.showLat = selAcr && latOk;
    stb.showPrf = selAcr && prfOk;
    stb.showLp  = selAcr && lpOk;
  end

  always_comb begin
    keyNext = keyState;
    if (pdEntered) begin
      keyNext = KEY_LOCKED;
    end else if (busWr && selKey) begin
      unique case (keyState)
        KEY_LOCKED: keyNext = (busWdata == KEY_A) ? KEY_HALF : KEY_BAD;
        KEY_HALF:   keyNext = (busWdata == KEY_B) ? KEY_OPEN : KEY_BAD;
        KEY_OPEN:   keyNext = KEY_OPEN;
        KEY_BAD:    keyNext = KEY_BAD;
        default:    keyNext = KEY_BAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_LOCKED;
    else       keyState <= keyNext;
  end

  // R7: a failed sequence only recovers through power-down entry
  a_r7_bad_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_BAD && !pdEntered) |=> (keyState == KEY_BAD));

  // R8: power-down entry always returns the key to its start state
  a_r8_key_relock: assert property (@(posedge clk) disable iff (!rstN)
    pdEntered |=> (keyState == KEY_LOCKED));

endmodule

// File: rtl/flash_acr_dp.sv
module flash_acr_dp
  import flash_acr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  acrStrobes_t       stb,
  input  logic [LAT_W-1:0]  wLat,
  input  logic              wPrf,
  input  logic              wLpm,
  input  logic              wPdr,
  input  logic              wSlp,
  input  logic              flashBusy,
  output logic [DATA_W-1:0] rdata,
  output logic [LAT_W-1:0]  latency,
  output logic              prefetchEn,
  output logic              lowPowerRead,
  output logic              pdRequest,
  output logic              memSleepPd
);

  logic [LAT_W-1:0] latQ;
  logic prfQ, lpmQ, pdrQ, slpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ <= '0;
      prfQ <= 1'b0;
      lpmQ <= 1'b0;
      pdrQ <= 1'b0;
      slpQ <= 1'b0;
    end else begin
      if (stb.wrLat) latQ <= wLat;
      if (stb.wrPrf) prfQ <= wPrf;
      if (stb.wrLpm) lpmQ <= wLpm;
      if (stb.wrSlp) slpQ <= wSlp;
      if (stb.clrPdr)     pdrQ <= 1'b0;
      else if (stb.wrPdr) pdrQ <= wPdr;
    end
  end

  always_comb begin
    rdata = '0;
    if (stb.showLat) rdata[LAT_LSB +: LAT_W] = latQ;
    if (stb.showPrf) rdata[PRF_BIT] = prfQ;
    if (stb.showLp) begin
      rdata[LPM_BIT] = lpmQ;
      rdata[PDR_BIT] = pdrQ;
      rdata[SLP_BIT] = slpQ;
    end
  end

  assign latency      = latQ;
  assign prefetchEn   = prfQ;
  assign lowPowerRead = lpmQ;
  assign pdRequest    = pdrQ;
  assign memSleepPd   = slpQ && !flashBusy;

endmodule

// File: rtl/flash_acr_regs.sv
module flash_acr_regs
  import flash_acr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busSecure,
  input  logic              busPriv,
  output logic [DATA_W-1:0] busRdata,
  input  logic              clkSecure,
  input  logic              lpSecure,
  input  logic              secPrivOnly,
  input  logic              nsPrivOnly,
  input  logic              flashBusy,
  input  logic              wbufPending,
  input  logic              pdEntered,
  output logic [LAT_W-1:0]  latency,
  output logic              prefetchEn,
  output logic              lowPowerRead,
  output logic              pdRequest,
  output logic              memSleepPd
);

  localparam logic [ADDR_W-1:0] ACR_OFS = 'h00;
  localparam logic [ADDR_W-1:0] KEY_OFS = 'h04;

  acrStrobes_t stb;
  logic keyOpen;

  flash_acr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .ACR_OFS(ACR_OFS), .KEY_OFS(KEY_OFS)) u_ctrl (
    .clk, .rstN, .busAddr, .busWdata, .busWr, .busSecure, .busPriv,
    .clkSecure, .lpSecure, .secPrivOnly, .nsPrivOnly,
    .flashBusy, .wbufPending, .pdEntered,
    .stb, .keyOpen
  );

  flash_acr_dp #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_dp (
    .clk, .rstN, .stb,
    .wLat(busWdata[LAT_LSB +: LAT_W]),
    .wPrf(busWdata[PRF_BIT]),
    .wLpm(busWdata[LPM_BIT]),
    .wPdr(busWdata[PDR_BIT]),
    .wSlp(busWdata[SLP_BIT]),
    .flashBusy,
    .rdata(busRdata),
    .latency, .prefetchEn, .lowPowerRead, .pdRequest, .memSleepPd
  );

  // R2: non-secure view of a secured latency field is zero
  a_r2_lat_raz: assert property (@(posedge clk) disable iff (!rstN)
    (clkSecure && !busSecure) |-> (busRdata[LAT_LSB +: LAT_W] == '0));

  // R2: non-secure write to a secured latency field is dropped
  a_r2_lat_wi: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ACR_OFS && clkSecure && !busSecure) |=> $stable(latency));

  // R6: low-power read bit frozen by busy or pending write buffer
  a_r6_lpm_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (flashBusy || wbufPending)) |=> $stable(lowPowerRead));

  // R7: request can only rise once the key is open
  a_r7_pdr_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdRequest) |-> $past(keyOpen));

  // R8: power-down entry clears the request
  a_r8_pdr_clear: assert property (@(posedge clk) disable iff (!rstN)
    pdEntered |=> !pdRequest);

endmodule

// File: tb/flash_acr_regs_test.sv
module flash_acr_regs_test;

  localparam logic [7:0]  ACR = 8'h00;
  localparam logic [7:0]  KEY = 8'h04;
  localparam logic [31:0] KA  = 32'h5A3C96E1;
  localparam logic [31:0] KB  = 32'hA5C3691E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busWr = 0, busSecure = 0, busPriv = 1;
  logic [31:0] busRdata;
  logic clkSecure = 0, lpSecure = 0, secPrivOnly = 0, nsPrivOnly = 0;
  logic flashBusy = 0, wbufPending = 0, pdEntered = 0;
  logic [3:0] latency;
  logic prefetchEn, lowPowerRead, pdRequest, memSleepPd;

  int runCnt = 0;
  int failCnt = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    bit          isPins;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  flash_acr_regs uut (
    .clk, .rstN, .busAddr, .busWdata, .busWr, .busSecure, .busPriv,
    .busRdata, .clkSecure, .lpSecure, .secPrivOnly, .nsPrivOnly,
    .flashBusy, .wbufPending, .pdEntered,
    .latency, .prefetchEn, .lowPowerRead, .pdRequest, .memSleepPd
  );

  // monitor: compares pending expectations away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = expQ.pop_front();
      act = it.isPins ? {24'h0, memSleepPd, pdRequest, lowPowerRead, prefetchEn, latency}
                      : busRdata;
      runCnt++;
      if (act !== it.exp) begin
        failCnt++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1;
    @(posedge clk); #1;
    busWr = 0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    busAddr = a; busWr = 0;
    expQ.push_back('{exp: e, isPins: 1'b0, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic pinChk(input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back('{exp: {24'h0, e}, isPins: 1'b1, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic pdPulse();
    @(posedge clk); #1; pdEntered = 1;
    @(posedge clk); #1; pdEntered = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state and layout
    rdChk(ACR, 32'h0, "R1 reset word");
    pinChk(8'h00, "R1 reset pins");
    wr(ACR, 32'hFFFF_FFFF);
    rdChk(ACR, 32'h0000_490F, "R1 layout, other bits zero");
    rdChk(KEY, 32'h0, "R1 key reads zero");
    pinChk(8'hBF, "R10 field outputs");

    // R2 latency security
    clkSecure = 1;
    wr(ACR, 32'h0000_4900);
    rdChk(ACR, 32'h0000_4900, "R2 ns read hides latency");
    busSecure = 1;
    rdChk(ACR, 32'h0000_490F, "R2 ns write ignored");
    wr(ACR, 32'h0000_4903);
    rdChk(ACR, 32'h0000_4903, "R2 secure write");
    busSecure = 0; clkSecure = 0;

    // R3 low-power group security
    lpSecure = 1;
    wr(ACR, 32'h0);
    rdChk(ACR, 32'h0, "R3 ns read hides lp group");
    busSecure = 1;
    rdChk(ACR, 32'h0000_4800, "R3 ns write ignored on lp group");
    busSecure = 0; lpSecure = 0;

    // R4 privilege, non-secure fields
    nsPrivOnly = 1; busPriv = 0;
    wr(ACR, 32'h0000_0105);
    rdChk(ACR, 32'h0, "R4 unpriv read zero");
    busPriv = 1;
    rdChk(ACR, 32'h0000_4800, "R4 unpriv write ignored");
    nsPrivOnly = 0;

    // R4/R5 secure privilege: latency blocked, prefetch and ns lp group writable
    clkSecure = 1; secPrivOnly = 1; busSecure = 1; busPriv = 0;
    wr(ACR, 32'h0000_0107);
    busPriv = 1;
    rdChk(ACR, 32'h0000_0100, "R4 sec-priv latency blocked");
    pinChk(8'h10, "R5 prefetch ignores secPrivOnly");
    clkSecure = 0; secPrivOnly = 0; busSecure = 0;

    // R6 low-power read change rejected while busy / buffer pending
    flashBusy = 1;
    wr(ACR, 32'h0000_0800);
    rdChk(ACR, 32'h0, "R6 lpm blocked by busy");
    flashBusy = 0; wbufPending = 1;
    wr(ACR, 32'h0000_0800);
    rdChk(ACR, 32'h0, "R6 lpm blocked by wbuf");
    wbufPending = 0;
    wr(ACR, 32'h0000_0800);
    rdChk(ACR, 32'h0000_0800, "R6 lpm written when idle");

    // R7 key sequence
    wr(ACR, 32'h0000_1000);
    rdChk(ACR, 32'h0, "R7 request locked");
    wr(KEY, KA);
    wr(KEY, 32'h1234_5678);
    wr(KEY, KA);
    wr(KEY, KB);
    wr(ACR, 32'h0000_1000);
    rdChk(ACR, 32'h0, "R7 wrong key stays locked");
    pdPulse();
    wr(KEY, KA);
    wr(KEY, KB);
    wr(ACR, 32'h0000_1000);
    rdChk(ACR, 32'h0000_1000, "R7 unlocked write");
    pinChk(8'h40, "R7 request pin");

    // R8 power-down entry clears and relocks
    pdPulse();
    rdChk(ACR, 32'h0, "R8 request cleared");
    wr(ACR, 32'h0000_1000);
    rdChk(ACR, 32'h0, "R8 key relocked");

    // R9 sleep power-down gating
    wr(ACR, 32'h0000_4000);
    pinChk(8'h80, "R9 sleep pd out when idle");
    flashBusy = 1;
    pinChk(8'h00, "R9 sleep pd held off while busy");
    rdChk(ACR, 32'h0000_4000, "R9 stored select kept");
    flashBusy = 0;
    pinChk(8'h80, "R9 sleep pd returns");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule